// File: doc/BRIEF.md
# Shared-Count Port Input Debouncer

This block filters the input pins of one 8-pin general purpose port against contact bounce and glitches. Every pin passes through a synchroniser. It then reaches either a bypass path or a per-pin stability filter. The filtered vector drives the port's input data register and its interrupt detectors, which sit outside this block.

Software controls filtering through two registers. A per-pin enable register is written with a masked write, so one pin can be changed without a read-modify-write. A single 8-bit stable-time register is shared by all pins of the port and holds a number of milliseconds. A millisecond strobe arrives from an external prescaler. On an enabled pin, a new input level is accepted only after it has held for the programmed number of strobes. A stable time of zero turns filtering off for the whole port.

Top module: `port_debounce`

## Requirements
- R1: After reset the filtered outputs, the enable register and the stable-time register are all 0.
- R2: A pin whose enable bit is 0 shows its input level on its filtered output exactly SYNC_STAGES+1 clock cycles (3 by default) after the input changes.
- R3: A write strobe on the stable-time register loads its 8-bit data on the next clock edge. The value reads back on `cfg_cnt_q` and applies to every pin. Without a strobe the register holds its value.
- R4: An enable write carries a mask in bits [15:8] and new values in bits [7:0]. Only pins whose mask bit is 1 take the new value, and the others keep theirs. Clearing the enable of a pin that has a pending change makes its output follow its input from the next cycle.
- R5: With its enable at 1 and a stable time N from 1 to 255, a pin's output changes only on a clock edge that samples `ms_tick` high. It changes on the Nth sampled strobe during which the synchronised input has differed from the output. Without strobes it never changes.
- R6: If the synchronised input returns to the output level, that pin's strobe count restarts from zero. The next change then needs N fresh strobes.
- R7: A stable time of 0 makes every pin follow its input as in R2, whatever its enable bit.
- R8: The full stable time of 255 is honoured. After 254 strobes the output is unchanged, and it changes on the 255th.
- R9: When a strobe and a register write are sampled on the same edge, the strobe is judged against the register values held before the write. The written values take effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle millisecond strobe from the prescaler |
| pin_raw | input | 8 | Asynchronous pin levels |
| cfg_cnt_wr | input | 1 | Write strobe for the stable-time register |
| cfg_cnt_wdata | input | 8 | Stable time in milliseconds |
| cfg_en_wr | input | 1 | Write strobe for the enable register |
| cfg_en_wdata | input | 16 | [15:8] per-pin write mask, [7:0] per-pin enable values |
| pin_filt | output | 8 | Filtered pin levels |
| cfg_en_q | output | 8 | Current per-pin enable bits |
| cfg_cnt_q | output | 8 | Current stable time |

## Verification
A millisecond strobe and a configuration write can land on the same clock edge. In that case the filter must decide with the old configuration. The bench provokes this on a pending change with one strobe already counted and a stable time of 2. In one cycle it raises `ms_tick` together with a write that raises the stable time to 5. It then expects the pending change to appear on that same edge and the register to read 5 afterwards. The same ordering applies to an enable write that lands beside a pending count: the affected pin is expected to release only on the following edge.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

   localparam int unsigned PDB_PINS  = 8;
   localparam int unsigned PDB_CNT_W = 8;

   // masked merge: bits with mask 1 take the new value, others keep the old
   function automatic logic [PDB_PINS-1:0] pdb_merge(
      input logic [PDB_PINS-1:0] old_v,
      input logic [PDB_PINS-1:0] mask,
      input logic [PDB_PINS-1:0] new_v);
      return (old_v & ~mask) | (new_v & mask);
   endfunction

endpackage

// File: rtl/pdb_sync.sv
module pdb_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("pdb_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic [WIDTH-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= d_i;
         end
         assign q_o = s_q;
      end else begin : g_chain
         logic [WIDTH-1:0] s_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) s_q[i] <= '0;
            end else begin
               s_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) s_q[i] <= s_q[i-1];
            end
         end
         assign q_o = s_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pdb_cfg_regs.sv
module pdb_cfg_regs
   import pdb_pkg::*;
#(
   parameter int unsigned PINS  = PDB_PINS,
   parameter int unsigned CNT_W = PDB_CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_wr_i,
   input  logic [CNT_W-1:0]  cnt_wdata_i,
   input  logic              en_wr_i,
   input  logic [2*PINS-1:0] en_wdata_i,
   output logic [PINS-1:0]   en_q_o,
   output logic [CNT_W-1:0]  cnt_q_o
);

   localparam int unsigned MSK_LSB = PINS;

   logic [PINS-1:0]  wr_mask;
   logic [PINS-1:0]  wr_val;
   logic [PINS-1:0]  en_q;
   logic [CNT_W-1:0] cnt_q;

   assign wr_mask = en_wdata_i[MSK_LSB +: PINS];
   assign wr_val  = en_wdata_i[0 +: PINS];

   generate
      if (PINS == PDB_PINS) begin : g_pkg_merge
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       en_q <= '0;
            else if (en_wr_i) en_q <= pdb_merge(en_q, wr_mask, wr_val);
         end
      end else begin : g_local_merge
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       en_q <= '0;
            else if (en_wr_i) en_q <= (en_q & ~wr_mask) | (wr_val & wr_mask);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (cnt_wr_i) cnt_q <= cnt_wdata_i;
   end

   assign en_q_o  = en_q;
   assign cnt_q_o = cnt_q;

   // R4: pins outside the write mask keep their enable
   a_r4_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr_i |=> (((en_q ^ $past(en_q)) & ~$past(wr_mask)) == '0));

   // R3: stable time only moves on a write strobe
   a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr_i |=> $stable(cnt_q));

endmodule

// File: rtl/pdb_pin_filter.sv
module pdb_pin_filter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             sync_i,
   output logic             filt_o
);

   logic             filt_q;
   logic [CNT_W-1:0] ctr_q;
   logic [CNT_W:0]   ctr_nxt;
   logic             bypass;
   logic             differs;
   logic             mature;

   assign bypass  = !en_i || (cnt_i == '0);
   assign differs = (sync_i != filt_q);
   assign ctr_nxt = {1'b0, ctr_q} + {{CNT_W{1'b0}}, 1'b1};
   assign mature  = (ctr_nxt >= {1'b0, cnt_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b0;
         ctr_q  <= '0;
      end else if (bypass) begin
         filt_q <= sync_i;
         ctr_q  <= '0;
      end else if (!differs) begin
         ctr_q  <= '0;
      end else if (tick_i) begin
         if (mature) begin
            filt_q <= sync_i;
            ctr_q  <= '0;
         end else begin
            ctr_q  <= ctr_nxt[CNT_W-1:0];
         end
      end
   end

   assign filt_o = filt_q;

   // R2: a disabled pin takes the synchronised level on the next edge
   a_r2_pass_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (filt_q == $past(sync_i)));

   // R7: a zero stable time behaves as a bypass
   a_r7_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_i == '0) |=> (filt_q == $past(sync_i)));

   // R5: while filtering, the output only moves on a sampled strobe
   a_r5_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_i) && ($past(cnt_i) != '0) && (filt_q != $past(filt_q)))
         |-> $past(tick_i));

   // R6: matching input clears the stability count
   a_r6_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !differs |=> (ctr_q == '0));

   // R8: the stability count never reaches the all-ones value
   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_q != '1);

endmodule

// File: rtl/port_debounce.sv
module port_debounce
   import pdb_pkg::*;
#(
   parameter int unsigned PINS        = PDB_PINS,
   parameter int unsigned CNT_W       = PDB_CNT_W,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ms_tick,
   input  logic [PINS-1:0]   pin_raw,
   input  logic              cfg_cnt_wr,
   input  logic [CNT_W-1:0]  cfg_cnt_wdata,
   input  logic              cfg_en_wr,
   input  logic [2*PINS-1:0] cfg_en_wdata,
   output logic [PINS-1:0]   pin_filt,
   output logic [PINS-1:0]   cfg_en_q,
   output logic [CNT_W-1:0]  cfg_cnt_q
);

   generate
      if (PINS < 1 || PINS > 32) begin : g_bad_pins
         $error("port_debounce: PINS must be 1..32");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("port_debounce: CNT_W must be 1..16");
      end
   endgenerate

   logic [PINS-1:0]  pin_sync;
   logic [PINS-1:0]  en_q;
   logic [CNT_W-1:0] cnt_q;

   pdb_sync #(
      .WIDTH  (PINS),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_raw),
      .q_o   (pin_sync)
   );

   pdb_cfg_regs #(
      .PINS  (PINS),
      .CNT_W (CNT_W)
   ) i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnt_wr_i    (cfg_cnt_wr),
      .cnt_wdata_i (cfg_cnt_wdata),
      .en_wr_i     (cfg_en_wr),
      .en_wdata_i  (cfg_en_wdata),
      .en_q_o      (en_q),
      .cnt_q_o     (cnt_q)
   );

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      pdb_pin_filter #(
         .CNT_W (CNT_W)
      ) i_filter (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick_i (ms_tick),
         .en_i   (en_q[p]),
         .cnt_i  (cnt_q),
         .sync_i (pin_sync[p]),
         .filt_o (pin_filt[p])
      );
   end

   assign cfg_en_q  = en_q;
   assign cfg_cnt_q = cnt_q;

   // R1: everything is zero in the first cycle out of reset
   a_r1_reset_zero: assert property (@(posedge clk)
      $rose(rst_n) |-> (pin_filt == '0 && en_q == '0 && cnt_q == '0));

endmodule

// File: tb/test_port_debounce.sv
module test_port_debounce;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ms_tick = 1'b0;
   logic [7:0]  pin_raw = '0;
   logic        cfg_cnt_wr = 1'b0;
   logic [7:0]  cfg_cnt_wdata = '0;
   logic        cfg_en_wr = 1'b0;
   logic [15:0] cfg_en_wdata = '0;
   logic [7:0]  pin_filt;
   logic [7:0]  cfg_en_q;
   logic [7:0]  cfg_cnt_q;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   typedef struct {
      int         due;
      logic [7:0] mask;
      logic [7:0] value;
      string      tag;
   } exp_t;

   exp_t sb[$];
   exp_t it;

   always #2 clk = ~clk;

   always @(posedge clk) cyc++;

   port_debounce i_port_debounce (
      .clk           (clk),
      .rst_n         (rst_n),
      .ms_tick       (ms_tick),
      .pin_raw       (pin_raw),
      .cfg_cnt_wr    (cfg_cnt_wr),
      .cfg_cnt_wdata (cfg_cnt_wdata),
      .cfg_en_wr     (cfg_en_wr),
      .cfg_en_wdata  (cfg_en_wdata),
      .pin_filt      (pin_filt),
      .cfg_en_q      (cfg_en_q),
      .cfg_cnt_q     (cfg_cnt_q)
   );

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
      n_checks++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp_v);
      end
   endtask

   // monitor: pops expectations due in this cycle and compares filtered pins
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         it = sb.pop_front();
         if (it.due < cyc) begin
            n_checks++;
            n_fail++;
            $display("FAIL %s: actual missed expected due %0d", it.tag, it.due);
         end else begin
            check8(it.tag, pin_filt & it.mask, it.value & it.mask);
         end
      end
   end

   task automatic expect_filt(input int delay, input logic [7:0] mask,
                              input logic [7:0] value, input string tag);
      exp_t e;
      e.due = cyc + delay;
      e.mask = mask;
      e.value = value;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic tick();
      ms_tick = 1'b1;
      @(posedge clk);
      #1;
      ms_tick = 1'b0;
   endtask

   task automatic wr_cnt(input logic [7:0] v);
      cfg_cnt_wr = 1'b1;
      cfg_cnt_wdata = v;
      @(posedge clk);
      #1;
      cfg_cnt_wr = 1'b0;
   endtask

   task automatic wr_en(input logic [7:0] mask, input logic [7:0] v);
      cfg_en_wr = 1'b1;
      cfg_en_wdata = {mask, v};
      @(posedge clk);
      #1;
      cfg_en_wr = 1'b0;
   endtask

   bit done = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1 reset state
      check8("R1 filt", pin_filt, 8'h00);
      check8("R1 enable", cfg_en_q, 8'h00);
      check8("R1 count", cfg_cnt_q, 8'h00);

      // R2 bypass latency
      pin_raw = 8'hA5;
      expect_filt(2, 8'hFF, 8'h00, "R2 not before latency");
      expect_filt(3, 8'hFF, 8'hA5, "R2 follows after latency");
      idle(4);

      // R3 stable time register
      wr_cnt(8'd3);
      check8("R3 count readback", cfg_cnt_q, 8'd3);

      // R4 masked enable writes
      wr_en(8'h0F, 8'hFF);
      check8("R4 masked set", cfg_en_q, 8'h0F);
      wr_en(8'h01, 8'h00);
      check8("R4 single clear keeps others", cfg_en_q, 8'h0E);
      wr_en(8'h01, 8'h01);
      check8("R4 single set", cfg_en_q, 8'h0F);

      // R5 counting strobes
      pin_raw = 8'h5A;
      expect_filt(3, 8'hF0, 8'h50, "R2 disabled pins follow");
      idle(10);
      expect_filt(0, 8'h0F, 8'h05, "R5 no strobe no change");
      tick();
      tick();
      expect_filt(0, 8'h0F, 8'h05, "R5 two of three strobes");
      tick();
      expect_filt(0, 8'h0F, 8'h0A, "R5 third strobe accepts");

      // R6 bounce restarts count
      pin_raw = 8'h55;
      idle(4);
      tick();
      tick();
      expect_filt(0, 8'h0F, 8'h0A, "R6 pending before bounce");
      pin_raw = 8'h5A;
      idle(4);
      pin_raw = 8'h55;
      idle(4);
      tick();
      tick();
      expect_filt(0, 8'h0F, 8'h0A, "R6 count restarted");
      tick();
      expect_filt(0, 8'h0F, 8'h05, "R6 accepted after fresh count");

      // R4 clearing enable releases a pending change
      pin_raw = 8'h5A;
      idle(4);
      tick();
      wr_en(8'h01, 8'h00);
      expect_filt(0, 8'h0F, 8'h05, "R4 write edge still filtered");
      expect_filt(1, 8'h01, 8'h00, "R4 release after clear");
      idle(2);
      expect_filt(0, 8'h0E, 8'h04, "R4 other pins still pending");
      wr_en(8'h01, 8'h01);

      // R7 zero stable time bypasses enabled pins
      wr_cnt(8'd0);
      expect_filt(1, 8'hFF, 8'h5A, "R7 zero count bypass");
      idle(2);
      pin_raw = 8'hC3;
      expect_filt(3, 8'hFF, 8'hC3, "R7 follows with latency");
      idle(4);

      // R9 strobe and write on the same edge
      wr_cnt(8'd2);
      pin_raw = 8'h3C;
      idle(4);
      tick();
      ms_tick = 1'b1;
      cfg_cnt_wr = 1'b1;
      cfg_cnt_wdata = 8'd5;
      @(posedge clk);
      #1;
      ms_tick = 1'b0;
      cfg_cnt_wr = 1'b0;
      expect_filt(0, 8'h0F, 8'h0C, "R9 strobe uses old count");
      check8("R9 new count after edge", cfg_cnt_q, 8'd5);

      // R8 full-range stable time
      wr_cnt(8'd255);
      pin_raw = 8'h33;
      idle(4);
      repeat (254) tick();
      expect_filt(0, 8'h0F, 8'h0C, "R8 254 strobes no change");
      tick();
      expect_filt(0, 8'h0F, 8'h03, "R8 255th strobe accepts");

      idle(6);
      if (sb.size() != 0) begin
         n_checks++;
         n_fail++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule